// File: doc/BRIEF.md
# Dual-Input Programmable Feedback Divider

This block produces the two pulse trains that a frequency synthesizer's phase comparator needs. The feedback divider counts oscillator events from one of two inputs. The first is a low-band input that goes straight into the counter. The second is a high-band input that is first halved by a fixed divide-by-2 stage. A band-select bit picks the input. The divider emits a single-cycle pulse once every N selected events. A second divider of the same kind, without the input selector, counts reference crystal events. It emits a pulse every R events, and R sets the tuning step.

All oscillator inputs are modelled as clock-enable strobes in a single clock domain. Software writes the moduli N and R and the band bit. Each counter picks up a new modulus only when it reloads, so a period that is already running always finishes with the modulus it started with. Modulus values of 0 and 1 are raised to 2, which makes every usable value from 2 up to the full counter width legal.

Top module: `dual_input_divider`

## Requirements
- R1: With `band_sel` = 1 (low band), `fb_pulse` is asserted once for every N events on `am_ev`, where N is `n_mod` in the range 2..65535.
- R2: With `band_sel` = 0 (high band), `fm_ev` events are first divided by 2, so `fb_pulse` is asserted once for every 2·N events on `fm_ev`.
- R3: The input that is not selected has no effect on `fb_pulse` timing, and idle cycles with no event do not advance any count.
- R4: The encoding of `band_sel` is 0 = high-band (`fm_ev`) path and 1 = low-band (`am_ev`) path.
- R5: A modulus value of 0 or 1 divides by 2. As a result, no output is ever high in two consecutive cycles.
- R6: A modulus changed by software takes effect at the next reload. The period in progress still uses the value loaded at its start.
- R7: `ref_pulse` is asserted once every R events on `xtal_ev`, where R is `r_mod`. It is independent of the band selection and of the other inputs.
- R8: Each output pulse lasts one cycle and is registered. It appears in the cycle after the clock edge that samples the event completing the count.
- R9: While `rst_n` is low, and afterwards until an event arrives, both outputs stay low. The first pulse after reset comes on exactly the N-th (or R-th) counted event.
- R10: The largest modulus, 65535, gives exactly 65535 events per pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| am_ev | input | 1 | Low-band oscillator event strobe |
| fm_ev | input | 1 | High-band oscillator event strobe (prescaled by 2) |
| xtal_ev | input | 1 | Reference crystal event strobe |
| band_sel | input | 1 | 1 selects low band, 0 selects high band |
| n_mod | input | W (16) | Feedback divider modulus |
| r_mod | input | W (16) | Reference divider modulus |
| fb_pulse | output | 1 | Feedback divider output pulse |
| ref_pulse | output | 1 | Reference divider output pulse |

## Verification
The hardest situation to reach is a modulus change that lands while a period is already running, because from the ports the bench cannot see where the counter stands. The stimulus solves this by first running the counter until a pulse appears, which places the reload at a known cycle. It then writes the new modulus in the very next cycle and measures the event count of the current period and of the period after it. The high-band prescaler phase is just as hidden, so the high-band periods are measured only from one pulse to the next, and each gap must equal 2·N whatever phase the prescaler starts in.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
    typedef enum logic {
        BAND_FM = 1'b0,
        BAND_AM = 1'b1
    } band_e;
endpackage

// File: rtl/fdiv_prescale2.sv
// Fixed divide-by-2 on an event strobe: passes every second event.
module fdiv_prescale2 (
    input  logic clk,
    input  logic rst_n,
    input  logic in_ev,
    output logic out_ev
);
    typedef struct packed {
        logic phase;
    } pre_state_t;

    pre_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        out_ev = in_ev & st_q.phase;
        if (in_ev) begin
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fdiv_counter.sv
// Programmable modulus counter; registered one-cycle pulse every M events.
module fdiv_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ev,
    input  logic [W-1:0] modulus,
    output logic         pulse
);
    localparam logic [W-1:0] MIN_MOD = W'(2);
    localparam logic [W-1:0] ONE     = W'(1);

    typedef struct packed {
        logic [W-1:0] left;   // events still needed; 0 = not yet loaded
        logic         pulse;
    } cnt_state_t;

    cnt_state_t   st_d, st_q;
    logic [W-1:0] eff_mod;
    logic [W-1:0] remaining;

    always_comb begin
        eff_mod   = (modulus < MIN_MOD) ? MIN_MOD : modulus;
        remaining = (st_q.left == '0) ? eff_mod : st_q.left;
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (ev) begin
            if (remaining == ONE) begin
                st_d.pulse = 1'b1;
                st_d.left  = eff_mod;
            end else begin
                st_d.left  = remaining - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse = st_q.pulse;
endmodule

// File: rtl/dual_input_divider.sv
module dual_input_divider
    import fdiv_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         am_ev,
    input  logic         fm_ev,
    input  logic         xtal_ev,
    input  logic         band_sel,
    input  logic [W-1:0] n_mod,
    input  logic [W-1:0] r_mod,
    output logic         fb_pulse,
    output logic         ref_pulse
);
    logic fm_half;
    logic sel_ev;

    fdiv_prescale2 u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_ev  (fm_ev),
        .out_ev (fm_half)
    );

    always_comb begin
        if (band_e'(band_sel) == BAND_AM) begin
            sel_ev = am_ev;
        end else begin
            sel_ev = fm_half;
        end
    end

    fdiv_counter #(.W(W)) u_fb_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (sel_ev),
        .modulus (n_mod),
        .pulse   (fb_pulse)
    );

    fdiv_counter #(.W(W)) u_ref_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (xtal_ev),
        .modulus (r_mod),
        .pulse   (ref_pulse)
    );
endmodule

// File: rtl/fdiv_checker.sv
module fdiv_checker (
    input logic clk,
    input logic rst_n,
    input logic am_ev,
    input logic fm_ev,
    input logic xtal_ev,
    input logic band_sel,
    input logic fm_half,
    input logic sel_ev,
    input logic fb_pulse,
    input logic ref_pulse
);
    p_fb_after_event_r1: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |-> $past(sel_ev));

    p_half_needs_fm_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fm_half |-> fm_ev);

    p_half_alternates_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fm_half |=> !fm_half);

    p_band_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ev |-> (band_sel ? am_ev : fm_ev));

    p_fb_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fb_pulse |=> !fb_pulse);

    p_ref_min_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |=> !ref_pulse);

    p_ref_after_xtal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ref_pulse |-> $past(xtal_ev));
endmodule

bind dual_input_divider fdiv_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .am_ev     (am_ev),
    .fm_ev     (fm_ev),
    .xtal_ev   (xtal_ev),
    .band_sel  (band_sel),
    .fm_half   (fm_half),
    .sel_ev    (sel_ev),
    .fb_pulse  (fb_pulse),
    .ref_pulse (ref_pulse)
);

// File: tb/dual_input_divider_test.sv
`timescale 1ns/1ps
module dual_input_divider_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         am_ev = 1'b0;
    logic         fm_ev = 1'b0;
    logic         xtal_ev = 1'b0;
    logic         band_sel = 1'b1;
    logic [W-1:0] n_mod = '0;
    logic [W-1:0] r_mod = '0;
    logic         fb_pulse;
    logic         ref_pulse;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_input_divider #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .am_ev(am_ev), .fm_ev(fm_ev),
        .xtal_ev(xtal_ev), .band_sel(band_sel), .n_mod(n_mod),
        .r_mod(r_mod), .fb_pulse(fb_pulse), .ref_pulse(ref_pulse)
    );

    always @(posedge clk) cycles <= cycles + 1;

    function automatic int eff(input int m);
        return (m < 2) ? 2 : m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_events();
        am_ev = 1'b0; fm_ev = 1'b0; xtal_ev = 1'b0;
    endtask

    // which: 0 = am, 1 = fm, 2 = xtal. Measures events per pulse.
    task automatic run(input int which, input int expect_cnt, input int nper,
                       input bit flush, input bit noise, input bit dense,
                       input string req);
        int  cnt = 0;
        int  got = 0;
        int  guard = 0;
        bit  armed = !flush;
        bit  p;
        bit  e;
        while (got < nper && guard < 150000) begin
            @(negedge clk);
            guard++;
            p = (which == 2) ? ref_pulse : fb_pulse;
            if (p) begin
                if (armed) begin
                    check(cnt == expect_cnt, req, cnt, expect_cnt);
                    got++;
                end
                armed = 1'b1;
                cnt = 0;
            end
            if (got < nper) begin
                e = dense || ((guard % 3) != 1);
                am_ev   = (which == 0) ? e : noise;
                fm_ev   = (which == 1) ? e : noise;
                xtal_ev = (which == 2) ? e : noise;
                if (e) cnt++;
            end
        end
        idle_events();
        if (got < nper) check(1'b0, {req, " timeout"}, got, nper);
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_events();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        #780000;
        check(1'b0, "watchdog", cycles, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        bit seen;
        do_reset();
        // R9: no pulse while idle after reset
        seen = 1'b0;
        repeat (10) begin
            @(negedge clk);
            if (fb_pulse || ref_pulse) seen = 1'b1;
        end
        check(!seen, "R9 idle after reset", int'(seen), 0);

        // R9/R1: first pulse on exactly the 5th event; R7 ref in parallel later
        band_sel = 1'b1; n_mod = 16'd5;
        run(0, 5, 2, 1'b0, 1'b0, 1'b0, "R9 first period");

        // R1/R4: low band sweep (band_sel=1 selects am_ev)
        for (int n = 2; n <= 24; n++) begin
            n_mod = W'(n);
            run(0, n, 2, 1'b1, 1'b0, 1'b0, "R1 am divide");
        end

        // R5: modulus 0 and 1 act as 2
        for (int n = 0; n <= 1; n++) begin
            n_mod = W'(n);
            run(0, 2, 3, 1'b1, 1'b0, 1'b1, "R5 small modulus");
        end

        // R3: unselected high-band input toggling every cycle
        n_mod = 16'd9;
        run(0, 9, 3, 1'b1, 1'b1, 1'b0, "R3 fm ignored");

        // R2/R4: high band sweep (band_sel=0 selects prescaled fm_ev)
        band_sel = 1'b0;
        for (int n = 0; n <= 12; n++) begin
            n_mod = W'(n);
            run(1, 2 * eff(n), 2, 1'b1, 1'b0, 1'b0, "R2 fm divide");
        end
        // R3: am_ev toggling while high band selected
        n_mod = 16'd6;
        run(1, 12, 2, 1'b1, 1'b1, 1'b1, "R3 am ignored");

        // R6: modulus change right after a reload applies one period later
        band_sel = 1'b1;
        n_mod = 16'd7;
        run(0, 7, 1, 1'b1, 1'b0, 1'b0, "R6 setup");
        n_mod = 16'd4;
        run(0, 7, 1, 1'b0, 1'b0, 1'b0, "R6 old modulus kept");
        run(0, 4, 2, 1'b0, 1'b0, 1'b0, "R6 new modulus");

        // R8: no pulse without events
        seen = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (fb_pulse || ref_pulse) seen = 1'b1;
        end
        check(!seen, "R8 no events no pulse", int'(seen), 0);

        // R7: reference divider with other inputs busy
        for (int r = 0; r <= 20; r++) begin
            r_mod = W'(r);
            run(2, eff(r), 2, 1'b1, 1'b1, 1'b0, "R7 ref divide");
        end

        // R10: full-range modulus from reset
        do_reset();
        r_mod = 16'hFFFF;
        run(2, 65535, 1, 1'b0, 1'b0, 1'b1, "R10 max modulus");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule